// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the 32-bit control and status word of a floating-point coprocessor. Software reads the whole word and writes it either as a full word or one exception field at a time. The arithmetic unit reports the exception bits of each operation it completes. The register keeps eight comparison condition codes, which are set or cleared by index and also presented as one packed byte. It drives the rounding-mode and flush-to-zero controls, and it raises a trap request to the exception logic.

The exception fields follow two different rules. The cause field describes only the most recent operation, so each report overwrites it. The flag field is sticky: it gathers exceptions across operations, and only software clears it. Condition code 0 sits at bit 23, and codes 1 to 7 sit at bits 25 to 31. Bit 24, which lies between them, is the flush-to-zero control. The packed output closes this gap.

Top module: `fcsr_unit`

## Requirements
- R1: After reset every bit of `rd_data` is 0, and `cc_vec`, `round_mode`, `flush_zero` and `trap_req` are all 0.
- R2: A write with `wr_sel` = 0 (full word) loads all 32 bits, and `rd_data` shows the new word after the clock edge. `round_mode` always equals bits 1:0 and `flush_zero` always equals bit 24. Bits 22:18 are a spare field that only a full-word write loads.
- R3: Condition code 0 is bit 23. Condition code n, for n from 1 to 7, is bit 24+n. A `cc_set` or `cc_clr` at index `cc_idx` changes only that bit. If both are asserted, the set wins.
- R4: `cc_vec[0]` equals register bit 23, and `cc_vec[7:1]` equals register bits 31:25.
- R5: `wr_sel` = 1 replaces the whole cause field, bits 17:12. `wr_sel` = 2 replaces only the enable field, bits 11:7. `wr_sel` = 3 replaces only the flag field, bits 6:2. All other bits keep their values.
- R6: On `rpt_valid`, the cause field takes `rpt_bits` in that clock edge. The bit weights within the field are inexact 1, underflow 2, overflow 4, divide-by-zero 8, invalid 16 and unimplemented 32.
- R7: `trap_req` is high while a cause bit 4:0 is set together with its matching enable bit. It is also high while cause bit 5 is set, whatever the enables hold.
- R8: On a report that requests no trap, `rpt_bits[4:0]` is ORed into the flags. On a report that does request a trap, the flags stay unchanged. A report never clears a flag.
- R9: When a report and a software cause write happen in the same cycle, the report wins the cause field. When an index set or clear happens in the same cycle as a full-word write, the index operation wins its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Software write strobe |
| wr_sel | input | 2 | Write target: 0 full word, 1 cause, 2 enable, 3 flags |
| wr_data | input | 32 | Write data in register bit positions |
| rpt_valid | input | 1 | Arithmetic unit reports an operation |
| rpt_bits | input | 6 | Exception bits of the reported operation |
| cc_set | input | 1 | Set the condition code at cc_idx |
| cc_clr | input | 1 | Clear the condition code at cc_idx |
| cc_idx | input | 3 | Condition code index |
| rd_data | output | 32 | Current register word |
| cc_vec | output | 8 | Packed condition codes, code n at bit n |
| round_mode | output | 2 | Rounding mode control |
| flush_zero | output | 1 | Flush-to-zero enable |
| trap_req | output | 1 | Exception trap request |

## Verification
The bench builds the block with its default parameters: eight condition codes, a five-bit enable and flag field, and a six-bit cause field. These widths are small enough to sweep fully. Every pairing of the 32 enable patterns with the 64 reported exception codes is applied, so every branch of the trap and flag-merge rule is reached. The bench also sets and clears each of the eight condition code indices on their own. This reaches the gap at bit 24 and every lane of the packed byte.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
    localparam int WORD_W    = 32;
    localparam int RM_LSB    = 0;
    localparam int RM_W      = 2;
    localparam int FLAG_LSB  = 2;
    localparam int EXC_W     = 5;
    localparam int EN_LSB    = FLAG_LSB + EXC_W;
    localparam int CAUSE_LSB = EN_LSB + EXC_W;
    localparam int CAUSE_W   = EXC_W + 1;
    localparam int SPARE_LSB = CAUSE_LSB + CAUSE_W;
    localparam int CC0_POS   = 23;
    localparam int SPARE_W   = CC0_POS - SPARE_LSB;
    localparam int FZ_POS    = 24;
    localparam int CCHI_LSB  = 25;
    localparam int NUM_CC    = WORD_W - CCHI_LSB + 1;

    typedef enum logic [1:0] {
        WR_WORD   = 2'd0,
        WR_CAUSE  = 2'd1,
        WR_ENABLE = 2'd2,
        WR_FLAGS  = 2'd3
    } wr_sel_e;
endpackage

// File: rtl/fcsr_cc_bank.sv
module fcsr_cc_bank #(
    parameter int NCC = 8,
    localparam int IW = $clog2(NCC)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [NCC-1:0] load_val,
    input  logic           set_i,
    input  logic           clr_i,
    input  logic [IW-1:0]  idx,
    output logic [NCC-1:0] cc_q
);
    for (genvar i = 0; i < NCC; i++) begin : g_cc
        logic hit;
        assign hit = (idx == IW'(i));
        always_ff @(posedge clk) begin
            if (!rst_n)               cc_q[i] <= 1'b0;
            else if (set_i && hit)    cc_q[i] <= 1'b1;
            else if (clr_i && hit)    cc_q[i] <= 1'b0;
            else if (load)            cc_q[i] <= load_val[i];
        end
    end
endmodule

// File: rtl/fcsr_exc_fields.sv
module fcsr_exc_fields #(
    parameter int EW = 5,
    localparam int CW = EW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_cause,
    input  logic          ld_en,
    input  logic          ld_flag,
    input  logic [CW-1:0] wr_cause,
    input  logic [EW-1:0] wr_en,
    input  logic [EW-1:0] wr_flag,
    input  logic          rpt_valid,
    input  logic [CW-1:0] rpt_bits,
    output logic [CW-1:0] cause_q,
    output logic [EW-1:0] en_q,
    output logic [EW-1:0] flag_q,
    output logic          trap
);
    logic [EW-1:0] en_next;
    logic [EW-1:0] flag_base;
    logic          rpt_traps;

    always_comb begin
        en_next   = ld_en ? wr_en : en_q;
        flag_base = ld_flag ? wr_flag : flag_q;
        rpt_traps = rpt_bits[EW] | (|(rpt_bits[EW-1:0] & en_next));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            en_q    <= '0;
            flag_q  <= '0;
        end else begin
            en_q <= en_next;
            if (rpt_valid)     cause_q <= rpt_bits;
            else if (ld_cause) cause_q <= wr_cause;
            if (rpt_valid && !rpt_traps) flag_q <= flag_base | rpt_bits[EW-1:0];
            else                         flag_q <= flag_base;
        end
    end

    assign trap = cause_q[EW] | (|(cause_q[EW-1:0] & en_q));
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
    import fcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rpt_valid,
    input  logic [CAUSE_W-1:0] rpt_bits,
    input  logic              cc_set,
    input  logic              cc_clr,
    input  logic [2:0]        cc_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic [NUM_CC-1:0] cc_vec,
    output logic [RM_W-1:0]   round_mode,
    output logic              flush_zero,
    output logic              trap_req
);
    wr_sel_e sel;
    logic ld_word, ld_cause, ld_en, ld_flag;
    logic [RM_W-1:0]    rm_q;
    logic               fz_q;
    logic [SPARE_W-1:0] spare_q;
    logic [CAUSE_W-1:0] cause_q;
    logic [EXC_W-1:0]   en_q, flag_q;
    logic [NUM_CC-1:0]  cc_q, cc_wr;

    always_comb begin
        sel      = wr_sel_e'(wr_sel);
        ld_word  = wr_valid && (sel == WR_WORD);
        ld_cause = ld_word || (wr_valid && sel == WR_CAUSE);
        ld_en    = ld_word || (wr_valid && sel == WR_ENABLE);
        ld_flag  = ld_word || (wr_valid && sel == WR_FLAGS);
        cc_wr    = {wr_data[WORD_W-1:CCHI_LSB], wr_data[CC0_POS]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rm_q    <= '0;
            fz_q    <= 1'b0;
            spare_q <= '0;
        end else if (ld_word) begin
            rm_q    <= wr_data[RM_LSB +: RM_W];
            fz_q    <= wr_data[FZ_POS];
            spare_q <= wr_data[SPARE_LSB +: SPARE_W];
        end
    end

    fcsr_cc_bank #(.NCC(NUM_CC)) u_cc (
        .clk(clk), .rst_n(rst_n), .load(ld_word), .load_val(cc_wr),
        .set_i(cc_set), .clr_i(cc_clr), .idx(cc_idx), .cc_q(cc_q)
    );

    fcsr_exc_fields #(.EW(EXC_W)) u_exc (
        .clk(clk), .rst_n(rst_n),
        .ld_cause(ld_cause), .ld_en(ld_en), .ld_flag(ld_flag),
        .wr_cause(wr_data[CAUSE_LSB +: CAUSE_W]),
        .wr_en(wr_data[EN_LSB +: EXC_W]),
        .wr_flag(wr_data[FLAG_LSB +: EXC_W]),
        .rpt_valid(rpt_valid), .rpt_bits(rpt_bits),
        .cause_q(cause_q), .en_q(en_q), .flag_q(flag_q), .trap(trap_req)
    );

    assign rd_data    = {cc_q[NUM_CC-1:1], fz_q, cc_q[0], spare_q,
                         cause_q, en_q, flag_q, rm_q};
    assign cc_vec     = cc_q;
    assign round_mode = rm_q;
    assign flush_zero = fz_q;
endmodule

// File: rtl/fcsr_unit_chk.sv
module fcsr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic [1:0]  wr_sel,
    input logic        rpt_valid,
    input logic [5:0]  rpt_bits,
    input logic        cc_set,
    input logic [2:0]  cc_idx,
    input logic [31:0] rd_data,
    input logic [7:0]  cc_vec,
    input logic [1:0]  round_mode,
    input logic        flush_zero,
    input logic        trap_req
);
    // R4
    packed_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_vec == {rd_data[31:25], rd_data[23]});

    // R2
    controls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        round_mode == rd_data[1:0] && flush_zero == rd_data[24]);

    // R8
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> ((rd_data[6:2] & $past(rd_data[6:2])) == $past(rd_data[6:2])));

    // R6
    cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |=> rd_data[17:12] == $past(rpt_bits));

    // R3
    cc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_set |=> cc_vec[$past(cc_idx)]);

    // R7
    unimpl_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[17] |-> trap_req);

    // R2
    spare_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && wr_sel == 2'd0) |=> $stable(rd_data[22:18]));
endmodule

bind fcsr_unit fcsr_unit_chk u_fcsr_unit_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
    .rpt_valid(rpt_valid), .rpt_bits(rpt_bits), .cc_set(cc_set),
    .cc_idx(cc_idx), .rd_data(rd_data), .cc_vec(cc_vec),
    .round_mode(round_mode), .flush_zero(flush_zero), .trap_req(trap_req)
);

// File: tb/fcsr_unit_bench.sv
`timescale 1ns/1ps
module fcsr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        rpt_valid;
    logic [5:0]  rpt_bits;
    logic        cc_set, cc_clr;
    logic [2:0]  cc_idx;
    logic [31:0] rd_data;
    logic [7:0]  cc_vec;
    logic [1:0]  round_mode;
    logic        flush_zero;
    logic        trap_req;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fcsr_unit u_fcsr_unit (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
        .wr_data(wr_data), .rpt_valid(rpt_valid), .rpt_bits(rpt_bits),
        .cc_set(cc_set), .cc_clr(cc_clr), .cc_idx(cc_idx),
        .rd_data(rd_data), .cc_vec(cc_vec), .round_mode(round_mode),
        .flush_zero(flush_zero), .trap_req(trap_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_valid = 0; wr_sel = 0; wr_data = 0;
        rpt_valid = 0; rpt_bits = 0;
        cc_set = 0; cc_clr = 0; cc_idx = 0;
    endtask

    // drive on negedge, one posedge, back at negedge for sampling
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic write(input logic [1:0] s, input logic [31:0] d);
        wr_valid = 1; wr_sel = s; wr_data = d;
        step();
    endtask

    function automatic logic [7:0] pack(input logic [31:0] w);
        return {w[31:25], w[23]};
    endfunction

    initial begin
        logic [31:0] exp_w;
        idle();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1", rd_data, 32'h0);
        check("R1", {cc_vec, round_mode, flush_zero, trap_req}, 32'h0);

        // R2 full-word load and control outputs
        exp_w = 32'hA5F5_F3D6;
        write(2'd0, exp_w);
        check("R2", rd_data, exp_w);
        check("R2", {round_mode, flush_zero}, {exp_w[1:0], exp_w[24]});
        check("R4", cc_vec, pack(exp_w));
        exp_w = 32'h5A7C_0C29;
        write(2'd0, exp_w);
        check("R2", rd_data, exp_w);
        check("R4", cc_vec, pack(exp_w));

        // R5 field writes touch only their own bits
        write(2'd0, 32'h0);
        write(2'd0, 32'hFFFF_FFFF & ~32'h0003_F000 | 32'h0000_0000);
        exp_w = rd_data;
        write(2'd1, 32'h0001_5000);
        check("R5 cause", rd_data, (exp_w & ~32'h0003_F000) | 32'h0001_5000);
        exp_w = rd_data;
        write(2'd2, 32'hFFFF_FFFF & ~32'h0000_0F80 | 32'h0000_0280);
        check("R5 enable", rd_data, (exp_w & ~32'h0000_0F80) | 32'h0000_0280);
        exp_w = rd_data;
        write(2'd3, 32'h0000_0028);
        check("R5 flags", rd_data, (exp_w & ~32'h0000_007C) | 32'h0000_0028);

        // R3 / R4 index set and clear of every code
        write(2'd0, 32'h0);
        for (int i = 0; i < 8; i++) begin
            cc_set = 1; cc_idx = 3'(i);
            step();
            exp_w = (i == 0) ? 32'h0080_0000 : (32'h1 << (24 + i));
            check("R3 set", rd_data, exp_w);
            check("R4 set", {24'h0, cc_vec}, 32'h1 << i);
            cc_clr = 1; cc_idx = 3'(i);
            step();
            check("R3 clr", rd_data, 32'h0);
        end
        write(2'd0, 32'hFEFF_FFFF & 32'hFE80_0000);
        cc_clr = 1; cc_idx = 3'd4;
        step();
        check("R3 clr one", {24'h0, cc_vec}, 32'hEF);
        check("R3 fz kept", {31'h0, flush_zero}, 32'h0);
        cc_set = 1; cc_clr = 1; cc_idx = 3'd4;
        step();
        check("R3 set wins", {24'h0, cc_vec}, 32'hFF);

        // R6 / R7 / R8 exhaustive enable x exception sweep
        for (int e = 0; e < 32; e++) begin
            for (int x = 0; x < 64; x++) begin
                logic [4:0] f0;
                logic       tr;
                logic [4:0] fx;
                f0 = 5'(e) ^ 5'h15;
                write(2'd0, {20'h0, 5'(e), f0, 2'b00});
                rpt_valid = 1; rpt_bits = 6'(x);
                step();
                tr = x[5] | (|(5'(x) & 5'(e)));
                fx = tr ? f0 : (f0 | 5'(x));
                check("R6 R8 word", rd_data, {14'h0, 6'(x), 5'(e), fx, 2'b00});
                check("R7 trap", {31'h0, trap_req}, {31'h0, tr});
            end
        end

        // R8 accumulation across reports, flags never cleared
        write(2'd0, 32'h0);
        rpt_valid = 1; rpt_bits = 6'h01; step();
        rpt_valid = 1; rpt_bits = 6'h08; step();
        rpt_valid = 1; rpt_bits = 6'h00; step();
        check("R8 accum", rd_data, {14'h0, 6'h00, 5'h00, 5'h09, 2'b00});

        // R9 report beats software cause write; index op beats word write
        wr_valid = 1; wr_sel = 2'd1; wr_data = 32'h0003_F000;
        rpt_valid = 1; rpt_bits = 6'h02;
        step();
        check("R9 cause", {26'h0, rd_data[17:12]}, 32'h02);
        wr_valid = 1; wr_sel = 2'd0; wr_data = 32'h0;
        cc_set = 1; cc_idx = 3'd6;
        step();
        check("R9 cc", {24'h0, cc_vec}, 32'h40);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc >= 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule